// File: doc/BRIEF.md
# Wide-to-Narrow Register Access Bridge

This block sits between a processor-side register port that moves K-bit words and a narrow control/status register bus that moves N-bit chunks, where K is a whole multiple of N. Each accepted processor request becomes a run of K/N narrow bus accesses. Each access handles one N-bit slice of the word. The processor gets a single one-cycle completion pulse when the run is over.

The narrow bus keeps a shadow copy of multi-chunk registers. A read of the lowest chunk snapshots the whole register. A write to the highest chunk commits what the earlier writes placed in the shadow. For this to work, the chunks of one word must be visited strictly from lowest to highest address, with nothing interleaved. The bridge guarantees that ordering. It places word W at narrow address W*(K/N) and issues one strobe per cycle. It rebuilds the read word from the chunk data that returns one cycle after each read strobe.

Top module: `csr_width_bridge`

## Requirements
- R1: After a synchronous active-high reset the bridge is idle. `csr_r_stb`, `csr_w_stb`, `cpu_ready` and `cpu_busy` are all low.
- R2: A request is accepted on a rising edge where `cpu_valid` is high and `cpu_busy` is low. `cpu_busy` is high from the next cycle until the completion pulse.
- R3: Each accepted request produces exactly K/N strobes of one kind, in K/N consecutive cycles, starting the cycle after acceptance. The strobe is `csr_w_stb` when `cpu_write` was 1 and `csr_r_stb` when it was 0.
- R4: During strobe i (i = 0 first) `csr_addr` equals `cpu_addr`*(K/N) + i. Addresses ascend by one per strobe.
- R5: During write strobe i, `csr_w_data` carries bits [i*N +: N] of the accepted `cpu_wdata`.
- R6: `csr_r_stb` and `csr_w_stb` are never high in the same cycle.
- R7: The narrow read data of strobe i, valid in the cycle after that strobe, lands in bits [i*N +: N] of `cpu_rdata`. At the completion pulse of a read, `cpu_rdata` holds all K/N chunks.
- R8: `cpu_ready` is a one-cycle pulse with `cpu_busy` low. For a write it comes in the cycle after the last write strobe. For a read it comes two cycles after the last read strobe, which is the cycle after the last chunk is captured.
- R9: `cpu_valid` asserted while `cpu_busy` is high is ignored. No strobe, address or data of the running request changes, and the new request is taken only once busy drops.
- R10: A request presented in the cycle of a completion pulse is accepted at once. Its first strobe follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write request, 0 = read request |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | CPU_W | Processor write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | A chunk run is in progress; requests are not taken |
| cpu_rdata | output | CPU_W | Assembled read word |
| csr_addr | output | CPU_AW+log2(CPU_W/CSR_W) | Narrow bus chunk address |
| csr_r_stb | output | 1 | Narrow bus read strobe |
| csr_w_stb | output | 1 | Narrow bus write strobe |
| csr_w_data | output | CSR_W | Narrow bus write chunk |
| csr_r_data | input | CSR_W | Narrow bus read chunk, valid the cycle after a read strobe, zero otherwise |

## Verification
Two things can happen in the same cycle at the end of a run. One is the completion pulse of a run. The other is the acceptance of the next request, together with the last read capture of a read run. The bench provokes this by presenting the next request in the very cycle where `cpu_ready` is high. It also keeps `cpu_valid` asserted with a different address and direction all through a running sequence. A behavioural model, made of a queue of expected per-cycle bus states, is compared against the ports every cycle. It judges three things: the old word is returned complete, the new run starts exactly one cycle later at its own address, and the early request left the running strobes untouched.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
  // Chunk sequencer phases: idle, strobing chunks, waiting for the last read chunk.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/csr_chunk_seq.sv
module csr_chunk_seq
  import csr_bridge_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  output logic             busy,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

  seq_state_e st;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_IDLE;
      idx    <= '0;
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      done   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st     <= SEQ_ISSUE;
            idx    <= '0;
            wr_q   <= start_wr;
            rd_stb <= !start_wr;
            wr_stb <= start_wr;
          end
        end
        SEQ_ISSUE: begin
          if (idx == LAST_IDX) begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            if (wr_q) begin
              st   <= SEQ_IDLE;
              done <= 1'b1;
            end else begin
              st <= SEQ_DRAIN;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SEQ_DRAIN: begin
          st   <= SEQ_IDLE;
          done <= 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (st != SEQ_IDLE);
endmodule

// File: rtl/csr_rd_gather.sv
module csr_rd_gather #(
  parameter int DW    = 8,
  parameter int RATIO = 4,
  parameter int IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_stb,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DW-1:0]       bus_rdata,
  output logic [DW*RATIO-1:0] word
);
  // Bus data follows its strobe by one cycle, so the strobe and index are delayed to match.
  logic             pend;
  logic [IDX_W-1:0] pidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      pidx <= '0;
    end else begin
      pend <= rd_stb;
      pidx <= idx;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_slot
    logic [DW-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst) slot <= '0;
      else if (pend && pidx == IDX_W'(g)) slot <= bus_rdata;
    end
    assign word[g*DW +: DW] = slot;
  end
endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge
  import csr_bridge_pkg::*;
#(
  parameter  int CPU_W  = 32,
  parameter  int CSR_W  = 8,
  parameter  int CPU_AW = 6,
  localparam int RATIO  = CPU_W / CSR_W,
  localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int CSR_AW = CPU_AW + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_W-1:0]  cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_busy,
  output logic [CPU_W-1:0]  cpu_rdata,
  output logic [CSR_AW-1:0] csr_addr,
  output logic              csr_r_stb,
  output logic              csr_w_stb,
  output logic [CSR_W-1:0]  csr_w_data,
  input  logic [CSR_W-1:0]  csr_r_data
);
  logic              start;
  logic [IDX_W-1:0]  idx;
  logic [CPU_AW-1:0] base_q;
  logic [CPU_W-1:0]  wdata_q;
  logic [CSR_W-1:0]  wchunk [RATIO];

  assign start = cpu_valid && !cpu_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      base_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  csr_chunk_seq #(
    .RATIO(RATIO),
    .IDX_W(IDX_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .start_wr(cpu_write),
    .busy    (cpu_busy),
    .rd_stb  (csr_r_stb),
    .wr_stb  (csr_w_stb),
    .done    (cpu_ready),
    .idx     (idx)
  );

  csr_rd_gather #(
    .DW   (CSR_W),
    .RATIO(RATIO),
    .IDX_W(IDX_W)
  ) u_gather (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (csr_r_stb),
    .idx      (idx),
    .bus_rdata(csr_r_data),
    .word     (cpu_rdata)
  );

  for (genvar g = 0; g < RATIO; g++) begin : g_wchunk
    assign wchunk[g] = wdata_q[g*CSR_W +: CSR_W];
  end

  assign csr_addr   = CSR_AW'(base_q) * CSR_AW'(RATIO) + CSR_AW'(idx);
  assign csr_w_data = csr_w_stb ? wchunk[idx] : '0;
endmodule

// File: rtl/csr_width_bridge_chk.sv
module csr_width_bridge_chk #(
  parameter int CSR_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_busy,
  input logic              cpu_ready,
  input logic              csr_r_stb,
  input logic              csr_w_stb,
  input logic [CSR_AW-1:0] csr_addr
);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(csr_r_stb && csr_w_stb));

  a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !cpu_busy |-> (!csr_r_stb && !csr_w_stb));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_busy) |=> cpu_busy);

  a_r4_read_addr_step: assert property (@(posedge clk) disable iff (rst)
    (csr_r_stb && $past(csr_r_stb)) |-> (csr_addr == $past(csr_addr) + 1'b1));

  a_r4_write_addr_step: assert property (@(posedge clk) disable iff (rst)
    (csr_w_stb && $past(csr_w_stb)) |-> (csr_addr == $past(csr_addr) + 1'b1));

  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  a_r8_ready_not_busy: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !cpu_busy);
endmodule

bind csr_width_bridge csr_width_bridge_chk #(.CSR_AW(CSR_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_valid(cpu_valid),
  .cpu_busy (cpu_busy),
  .cpu_ready(cpu_ready),
  .csr_r_stb(csr_r_stb),
  .csr_w_stb(csr_w_stb),
  .csr_addr (csr_addr)
);

// File: tb/test_csr_width_bridge.sv
module test_csr_width_bridge;
  localparam int CPU_W  = 32;
  localparam int CSR_W  = 8;
  localparam int CPU_AW = 6;
  localparam int RATIO  = CPU_W / CSR_W;
  localparam int CSR_AW = CPU_AW + 2;
  localparam int DEPTH  = 1 << CSR_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_valid = 1'b0;
  logic              cpu_write = 1'b0;
  logic [CPU_AW-1:0] cpu_addr = '0;
  logic [CPU_W-1:0]  cpu_wdata = '0;
  logic              cpu_ready, cpu_busy;
  logic [CPU_W-1:0]  cpu_rdata;
  logic [CSR_AW-1:0] csr_addr;
  logic              csr_r_stb, csr_w_stb;
  logic [CSR_W-1:0]  csr_w_data;
  logic [CSR_W-1:0]  csr_r_data = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  csr_width_bridge #(.CPU_W(CPU_W), .CSR_W(CSR_W), .CPU_AW(CPU_AW)) i_csr_width_bridge (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_busy(cpu_busy), .cpu_rdata(cpu_rdata), .csr_addr(csr_addr),
    .csr_r_stb(csr_r_stb), .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data),
    .csr_r_data(csr_r_data)
  );

  // Narrow-bus register space served by the bench: data one cycle after a read strobe, else zero.
  logic [CSR_W-1:0] mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) mem[i] = CSR_W'(i * 7 + 3);
  always @(posedge clk) begin
    csr_r_data <= csr_r_stb ? mem[csr_addr] : '0;
    if (csr_w_stb) mem[csr_addr] <= csr_w_data;
  end

  // Reference model: a queue of expected per-cycle port states.
  typedef struct {
    bit rs; bit ws; bit rdy; bit bsy; bit rd_end;
    int addr; logic [CSR_W-1:0] wd;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  function automatic exp_t idle_e();
    exp_t e;
    e.rs = 0; e.ws = 0; e.rdy = 0; e.bsy = 0; e.rd_end = 0; e.addr = 0; e.wd = '0;
    return e;
  endfunction

  initial cur = idle_e();

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = idle_e();
    end else begin
      bit acc;
      acc = cpu_valid && !cur.bsy;
      if (acc) begin
        for (int i = 0; i < RATIO; i++) begin
          exp_t e = idle_e();
          e.bsy = 1; e.rs = !cpu_write; e.ws = cpu_write;
          e.addr = int'(cpu_addr) * RATIO + i;
          e.wd = cpu_wdata[i*CSR_W +: CSR_W];
          q.push_back(e);
        end
        if (!cpu_write) begin
          exp_t d = idle_e();
          d.bsy = 1;
          q.push_back(d);
        end
        begin
          exp_t r = idle_e();
          r.rdy = 1; r.rd_end = !cpu_write; r.addr = int'(cpu_addr);
          q.push_back(r);
        end
      end
      cur = (q.size() > 0) ? q.pop_front() : idle_e();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Compare every cycle, away from the clock edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(csr_r_stb && csr_w_stb), "R6", "both strobes", {csr_r_stb, csr_w_stb}, 0);
      chk(csr_r_stb == cur.rs, "R3", "read strobe", csr_r_stb, cur.rs);
      chk(csr_w_stb == cur.ws, "R3", "write strobe", csr_w_stb, cur.ws);
      chk(cpu_busy == cur.bsy, "R2", "busy", cpu_busy, cur.bsy);
      chk(cpu_ready == cur.rdy, "R8", "ready", cpu_ready, cur.rdy);
      if (cur.rs || cur.ws)
        chk(int'(csr_addr) == cur.addr, "R4", "chunk address", csr_addr, cur.addr);
      if (cur.ws)
        chk(csr_w_data == cur.wd, "R5", "write chunk", csr_w_data, cur.wd);
      if (cur.rd_end) begin
        logic [CPU_W-1:0] w;
        for (int i = 0; i < RATIO; i++) w[i*CSR_W +: CSR_W] = mem[cur.addr * RATIO + i];
        chk(cpu_rdata == w, "R7", "assembled read", cpu_rdata, w);
      end
    end
  end

  // Present a request; it is taken on the first edge with busy low (R9 when held while busy).
  task automatic issue(input bit w, input int a, input logic [CPU_W-1:0] d);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = CPU_AW'(a); cpu_wdata = d;
    while (cpu_busy) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!cpu_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!csr_r_stb && !csr_w_stb && !cpu_busy && !cpu_ready, "R1", "reset idle",
        {csr_r_stb, csr_w_stb, cpu_busy, cpu_ready}, 0);

    // R3 R4 R5: write, then R7 read back
    issue(1, 5, 32'hA1B2_C3D4); wait_ready(); @(negedge clk);
    issue(0, 5, '0); wait_ready(); @(negedge clk);
    // Read of untouched initial pattern
    issue(0, 9, '0); wait_ready(); @(negedge clk);
    // Boundary addresses and data patterns
    issue(1, 0, 32'hFFFF_FFFF); wait_ready(); @(negedge clk);
    issue(1, 63, 32'h0000_0000); wait_ready(); @(negedge clk);
    issue(0, 63, '0); wait_ready(); @(negedge clk);
    issue(0, 0, '0); wait_ready();
    // R10: next request in the completion cycle, write then read back-to-back
    issue(1, 20, 32'h1357_9BDF); wait_ready();
    issue(0, 20, '0); wait_ready();
    issue(0, 21, '0); wait_ready();
    // R9: second request held high while the first runs
    issue(0, 10, '0);
    issue(1, 11, 32'hCAFE_F00D);
    wait_ready(); @(negedge clk);
    issue(1, 12, 32'h8421_1248);
    issue(0, 12, '0);
    wait_ready(); @(negedge clk);
    // Mixed pseudo-random sequence
    begin
      int unsigned s = 32'h1234_5678;
      for (int n = 0; n < 40; n++) begin
        s = s * 1103515245 + 12345;
        issue(s[3], int'(s[21:16]), s ^ (s << 7));
        if (s[9]) wait_ready();
      end
    end
    wait_ready();
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R3", "model drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule